// File: doc/BRIEF.md
# Debug Pin Unlock Sequence Detector

This block decides whether a pin shared between general-purpose I/O and a single-wire serial debug line may take on its debug role. It listens to the pin only while the chip's external reset input is held low. After an arming delay for the internal reset interval, it expects an 80H character and uses it to measure the serial bit period. It then expects four key bytes, EBH, 5AH, 70H and CDH, in that order.

When all four key bytes arrive correctly, an unlock flag is latched. Once external reset is released, that flag drives the pin mux to its debug function. Only power-on reset clears the flag.

A long low level on the line counts as a serial break. A break clears any partial sequence in the receiver. It does not touch an unlock that is already latched.

Top module: `dbg_unlock_det`

## Requirements
- R1: After power-on reset (`rst_ni` low), `unlock_o` is 0, `pin_sel_o` is 0 and `bit_period_o` is 0.
- R2: Line activity within the first ARM_CYCLES cycles after `ext_rst_ni` falls is ignored: a full sequence sent in that window leaves `unlock_o` at 0 and `bit_period_o` at 0.
- R3: The first character after arming is the autobaud character 80H. It is sent LSB first with a start bit, so the line is low for 8 bit times. `bit_period_o` becomes floor(low cycles / 8), and it must be at least 2 to be accepted.
- R4: After autobaud, the bytes EBH, 5AH, 70H and CDH, received in that order, set `unlock_o` to 1. Each byte is framed as 1 low start bit, 8 data bits LSB first and 1 high stop bit, and is sampled mid-bit.
- R5: A key byte that differs from the expected one at any position leaves `unlock_o` at 0. The detector then treats the next character as a new autobaud character.
- R6: A stop bit sampled low leaves `unlock_o` at 0. The detector then waits for a new autobaud character.
- R7: While `ext_rst_ni` is high, the line is ignored: `unlock_o` is not set and `bit_period_o` keeps its value.
- R8: `pin_sel_o` is 1 (debug function) exactly when `unlock_o` is 1 and `ext_rst_ni` is high; otherwise it is 0 (GPIO).
- R9: A line held low for BREAK_CYCLES consecutive sampled cycles is a break. It discards any partial sequence, and reception restarts with a new autobaud character once the line is high.
- R10: Once set, `unlock_o` stays 1 through breaks and through any toggling of `ext_rst_ni`; only `rst_ni` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pin level; low means the chip is held in reset |
| pin_i | input | 1 | Raw level of the shared pin, synchronised inside |
| unlock_o | output | 1 | Latched unlock flag |
| pin_sel_o | output | 1 | Pin mux select: 1 debug function, 0 GPIO |
| bit_period_o | output | CNT_W | Measured bit period in clock cycles |

## Verification
The hardest state to reach from the ports is a receiver that has lost character alignment partway through the key. This happens after a wrong byte, a framing error or a break, where the remaining characters can be mistaken for a fresh autobaud. The bench reaches it by cutting the key off at each position with a single corrupted byte, and separately by a low stop bit and by a break in mid-sequence. In each case it follows with a complete sequence at a different bit period, which only succeeds if the detector really went back to autobaud. The bit period is swept over every value from 4 to 20 cycles, including one low time that is not a multiple of 8.

// File: rtl/dbg_unlock_pkg.sv
package dbg_unlock_pkg;

  typedef enum logic [2:0] {
    RX_WAIT_HIGH,
    RX_ABAUD_IDLE,
    RX_ABAUD_LOW,
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;

  localparam int KEY_LEN = 4;

  function automatic logic [7:0] key_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    key_byte = 8'hEB;
      2'd1:    key_byte = 8'h5A;
      2'd2:    key_byte = 8'h70;
      default: key_byte = 8'hCD;
    endcase
  endfunction

endpackage

// File: rtl/dbg_sync.sv
module dbg_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  // idle level of the line is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dbg_arm_timer.sv
module dbg_arm_timer #(
  parameter int ARM_CYCLES = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  output logic armed_o
);
  localparam int CW = $clog2(ARM_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (ext_rst_ni)                  cnt_q <= '0;
    else if (cnt_q != CW'(ARM_CYCLES))    cnt_q <= cnt_q + 1'b1;
  end

  assign armed_o = (cnt_q == CW'(ARM_CYCLES));

  AST_ARMED_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |-> !$past(ext_rst_ni)); // R7
endmodule

// File: rtl/dbg_break_det.sv
module dbg_break_det #(
  parameter int BREAK_CYCLES = 40000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic brk_o
);
  localparam int BW = $clog2(BREAK_CYCLES + 1);

  logic [BW-1:0] low_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          low_q <= '0;
    else if (line_i)                      low_q <= '0;
    else if (low_q != BW'(BREAK_CYCLES))  low_q <= low_q + 1'b1;
  end

  assign brk_o = (low_q == BW'(BREAK_CYCLES));

  AST_BRK_NEEDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> !$past(line_i)); // R9
  AST_BRK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_o && !line_i) |=> brk_o); // R9
endmodule

// File: rtl/dbg_rx_core.sv
module dbg_rx_core
  import dbg_unlock_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             line_i,
  output logic [CNT_W-1:0] period_o,
  output logic             hit_o
);
  localparam int LW = CNT_W + 3;
  localparam int IW = $clog2(KEY_LEN);

  rx_state_e        state_q;
  logic [LW-1:0]    cnt_q;
  logic [CNT_W-1:0] period_q;
  logic [7:0]       shreg_q;
  logic [2:0]       bit_q;
  logic [IW-1:0]    idx_q;
  logic             hit_q;

  logic [LW-1:0] half_w, full_w;
  assign full_w = {3'b000, period_q};
  assign half_w = {4'b0000, period_q[CNT_W-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_WAIT_HIGH;
      cnt_q    <= '0;
      period_q <= '0;
      shreg_q  <= '0;
      bit_q    <= '0;
      idx_q    <= '0;
      hit_q    <= 1'b0;
    end else begin
      hit_q <= 1'b0;
      if (clr_i) begin
        state_q <= RX_WAIT_HIGH;
      end else begin
        unique case (state_q)
          RX_WAIT_HIGH: if (line_i) state_q <= RX_ABAUD_IDLE;
          RX_ABAUD_IDLE: if (!line_i) begin
            state_q <= RX_ABAUD_LOW;
            cnt_q   <= LW'(1);
          end
          RX_ABAUD_LOW: begin
            if (!line_i) begin
              if (cnt_q != {LW{1'b1}}) cnt_q <= cnt_q + 1'b1;
            end else if (cnt_q[LW-1:3] >= CNT_W'(2)) begin
              period_q <= cnt_q[LW-1:3];
              idx_q    <= '0;
              state_q  <= RX_IDLE;
            end else begin
              state_q  <= RX_ABAUD_IDLE;
            end
          end
          RX_IDLE: if (!line_i) begin
            state_q <= RX_START;
            cnt_q   <= LW'(1);
          end
          RX_START: begin
            if (cnt_q == half_w) begin
              if (line_i) state_q <= RX_IDLE; // glitch, not a start bit
              else begin
                state_q <= RX_DATA;
                cnt_q   <= LW'(1);
                bit_q   <= '0;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: begin
            if (cnt_q == full_w) begin
              shreg_q <= {line_i, shreg_q[7:1]};
              cnt_q   <= LW'(1);
              if (bit_q == 3'd7) state_q <= RX_STOP;
              else               bit_q   <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == full_w) begin
              if (!line_i) state_q <= RX_WAIT_HIGH;
              else if (shreg_q == key_byte(idx_q)) begin
                if (idx_q == IW'(KEY_LEN - 1)) begin
                  hit_q   <= 1'b1;
                  state_q <= RX_WAIT_HIGH;
                end else begin
                  idx_q   <= idx_q + 1'b1;
                  state_q <= RX_IDLE;
                end
              end else state_q <= RX_WAIT_HIGH;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= RX_WAIT_HIGH;
        endcase
      end
    end
  end

  assign period_o = period_q;
  assign hit_o    = hit_q;

  AST_PERIOD_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {RX_IDLE, RX_START, RX_DATA, RX_STOP}) |-> (period_q >= CNT_W'(2))); // R3
endmodule

// File: rtl/dbg_unlock_det.sv
module dbg_unlock_det #(
  parameter int ARM_CYCLES   = 100000,
  parameter int BREAK_CYCLES = 40000,
  parameter int CNT_W        = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_rst_ni,
  input  logic             pin_i,
  output logic             unlock_o,
  output logic             pin_sel_o,
  output logic [CNT_W-1:0] bit_period_o
);
  logic line, armed, brk, rx_clr, key_hit, unlock_q;

  dbg_sync u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(line)
  );

  dbg_arm_timer #(.ARM_CYCLES(ARM_CYCLES)) u_arm (
    .clk_i (clk_i), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .armed_o(armed)
  );

  dbg_break_det #(.BREAK_CYCLES(BREAK_CYCLES)) u_brk (
    .clk_i (clk_i), .rst_ni(rst_ni), .line_i(line), .brk_o(brk)
  );

  assign rx_clr = !armed || brk;

  dbg_rx_core #(.CNT_W(CNT_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (rx_clr),
    .line_i  (line),
    .period_o(bit_period_o),
    .hit_o   (key_hit)
  );

  // cleared by power-on reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      unlock_q <= 1'b0;
    else if (key_hit) unlock_q <= 1'b1;
  end

  assign unlock_o  = unlock_q;
  assign pin_sel_o = unlock_q && ext_rst_ni;

  AST_UNLOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_q |=> unlock_q); // R10
  AST_HIT_WHEN_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_hit |-> $past(armed)); // R2
  AST_HIT_NOT_IN_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_hit |-> !$past(brk)); // R9
endmodule

// File: tb/sim_dbg_unlock_det.sv
module sim_dbg_unlock_det;
  localparam int ARM   = 2000;
  localparam int BRK   = 200;
  localparam int CW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_n = 1'b1;
  logic pin = 1'b1;
  logic unlock, sel;
  logic [CW-1:0] period;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbg_unlock_det #(.ARM_CYCLES(ARM), .BREAK_CYCLES(BRK), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_rst_ni(ext_n), .pin_i(pin),
    .unlock_o(unlock), .pin_sel_o(sel), .bit_period_o(period)
  );

  function automatic logic [7:0] kb(int i);
    case (i)
      0: kb = 8'hEB;
      1: kb = 8'h5A;
      2: kb = 8'h70;
      default: kb = 8'hCD;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put(logic v, int n);
    pin = v;
    idle(n);
  endtask

  task automatic send_byte(logic [7:0] b, int p, logic stop);
    put(1'b0, p);
    for (int i = 0; i < 8; i++) put(b[i], p);
    put(stop, p);
    put(1'b1, 2 * p);
  endtask

  task automatic send_seq(int p);
    send_byte(8'h80, p, 1'b1);
    for (int i = 0; i < 4; i++) send_byte(kb(i), p, 1'b1);
  endtask

  task automatic por();
    rst_n = 1'b0; ext_n = 1'b1; pin = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic arm();
    ext_n = 1'b0;
    idle(ARM + 10);
  endtask

  task automatic brk_line();
    put(1'b0, BRK + 100);
    put(1'b1, 20);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    por();
    chk("R1 unlock", unlock, 0);
    chk("R1 pin_sel", sel, 0);
    chk("R1 period", period, 0);

    // R3 / R4: sweep every bit period
    for (int p = 4; p <= 20; p++) begin
      por(); arm();
      send_seq(p);
      chk("R3 period", period, p);
      chk("R4 unlock", unlock, 1);
    end

    // R3: low time not a multiple of 8 rounds down
    por(); arm();
    put(1'b0, 8 * 9 + 5); put(1'b1, 27);
    for (int i = 0; i < 4; i++) send_byte(kb(i), 9, 1'b1);
    chk("R3 floor period", period, 9);
    chk("R4 unlock floor", unlock, 1);

    // R2: sequence inside the arming delay is ignored
    por();
    ext_n = 1'b0; idle(5);
    send_seq(10);
    chk("R2 unlock", unlock, 0);
    chk("R2 period", period, 0);
    idle(ARM);
    send_seq(10);
    chk("R2 unlock after arm", unlock, 1);

    // R5: wrong byte at each position, then fresh autobaud works
    for (int k = 0; k < 4; k++) begin
      por(); arm();
      send_byte(8'h80, 11, 1'b1);
      for (int i = 0; i < k; i++) send_byte(kb(i), 11, 1'b1);
      send_byte(kb(k) ^ 8'h10, 11, 1'b1);
      chk("R5 no unlock", unlock, 0);
      send_seq(8);
      chk("R5 reautobaud period", period, 8);
      chk("R5 unlock after retry", unlock, 1);
    end

    // R6: low stop bit on last key byte
    por(); arm();
    send_byte(8'h80, 10, 1'b1);
    for (int i = 0; i < 3; i++) send_byte(kb(i), 10, 1'b1);
    send_byte(kb(3), 10, 1'b0);
    chk("R6 no unlock", unlock, 0);
    send_seq(12);
    chk("R6 period", period, 12);
    chk("R6 unlock after retry", unlock, 1);

    // R7: external reset high ignores the line
    por();
    send_seq(10);
    chk("R7 unlock", unlock, 0);
    chk("R7 period", period, 0);
    chk("R8 sel locked", sel, 0);
    arm();
    send_byte(8'h80, 12, 1'b1);
    ext_n = 1'b1; idle(5);
    send_byte(8'h80, 6, 1'b1);
    for (int i = 0; i < 4; i++) send_byte(kb(i), 6, 1'b1);
    chk("R7 period kept", period, 12);
    chk("R7 unlock kept", unlock, 0);

    // R8: mux select
    por(); arm();
    send_seq(10);
    chk("R8 unlock", unlock, 1);
    chk("R8 sel in reset", sel, 0);
    ext_n = 1'b1; idle(2);
    chk("R8 sel released", sel, 1);

    // R9: break mid-sequence discards partial key
    por(); arm();
    send_byte(8'h80, 10, 1'b1);
    send_byte(kb(0), 10, 1'b1);
    send_byte(kb(1), 10, 1'b1);
    brk_line();
    send_byte(kb(2), 10, 1'b1);
    send_byte(kb(3), 10, 1'b1);
    chk("R9 no unlock", unlock, 0);
    brk_line();
    send_seq(14);
    chk("R9 period", period, 14);
    chk("R9 unlock after break", unlock, 1);

    // R10: break and external reset toggles keep unlock
    brk_line();
    chk("R10 after break", unlock, 1);
    ext_n = 1'b1; idle(10);
    ext_n = 1'b0; idle(50);
    ext_n = 1'b1; idle(2);
    chk("R10 after ext toggle", unlock, 1);
    chk("R8 sel after toggle", sel, 1);
    rst_n = 1'b0; idle(2);
    chk("R10 cleared by por", unlock, 0);
    rst_n = 1'b1; idle(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule